// File: doc/BRIEF.md
# Event-Driven Backplane Readout Master

This block is the master of a shared backplane that carries up to sixteen readout slaves. Trigger numbers arrive on a valid/ready stream and wait in a small trigger queue. For each queued number the master first runs a broadcast cycle. It puts the number on the backplane, drops a trigger-valid strobe and waits for the wired acknowledge that all slaves have answered. It then captures every slave's data-ready line. Next it visits only the slaves that claimed data, lowest address first. It opens each one with an address strobe and pulls words through a data-strobe / data-acknowledge handshake until the slave flags end of block.

Every non-empty frame enters the data FIFO as one header word that holds the trigger number, followed by all slave words for that trigger. A downstream valid/ready port drains the FIFO on its own. The bus side stalls only when the FIFO is full. The output side stalls only when the FIFO is empty or the consumer lowers ready because its memory is full. A trigger that no slave claims writes nothing, and the master goes straight to the next broadcast cycle. A programmable timeout guards every wait on a slave response. A frame timer reports the length of the most recent transaction. A diagnostic mode keeps the master off the bus and lets a host pop the trigger queue and push words into the data FIFO.

Top module: `evt_readout_master`

## Requirements
- R1: `trig_ready` is high exactly when the trigger queue (depth `TQ_DEPTH`, default 8) has room. Queued trigger numbers are served, and appear on `tq_head`, in arrival order.
- R2: For a broadcast cycle, `bp_tnum` holds the trigger number for at least `SETUP` cycles with `bp_tvalid_n` high before `bp_tvalid_n` goes low. It stays stable while `bp_tvalid_n` is low. `bp_tvalid_n` rises one cycle after `bp_back` is seen high, and no new cycle starts until `bp_back` has fallen.
- R3: A slave is read only if its active-low `bp_ready_n` bit was low when `bp_back` was seen high. Claimed slaves are read in ascending address order.
- R4: `bp_addr` is driven for at least `SETUP` cycles with `bp_as_n` high before `bp_as_n` falls, and it stays stable while `bp_as_n` is low.
- R5: Each word transfer lowers `bp_ds_n` (only while `bp_as_n` is low) and waits for `bp_dk_n` low. The master then stores `bp_data` and raises `bp_ds_n`, and it waits for `bp_dk_n` high before the next transfer.
- R6: The word taken while `bp_eob_n` is low is the last word of that slave. After the handshake completes, `bp_as_n` rises and the next claimed slave is opened.
- R7: If no slave claims data, the trigger writes no words and opens no slave. The next queued trigger starts its broadcast cycle directly.
- R8: A frame on the output is a header word (`out_hdr`=1, `out_data` = trigger number in bits 7:0, upper bits zero) followed by data words (`out_hdr`=0, `out_data` = slave word).
- R9: `bp_ds_n` is never lowered while the data FIFO is full. `out_valid` is high while the FIFO holds a word, and a word stays on `out_data` until a cycle with `out_ready` high.
- R10: A nonzero `tmo_limit` of L ends any wait for a slave response that lasts L cycles. The master releases all strobes, drops the rest of that trigger, and holds `timeout_flag` high until the next broadcast cycle begins. A limit of 0 disables the timeout.
- R11: `frame_cycles` gives the number of clock edges from the edge that lowers `bp_tvalid_n` to the edge that ends the transaction (the final rise of `bp_as_n`, the release of trigger-valid for an empty frame, or a timeout).
- R12: While `diag_mode` is high the master leaves every backplane strobe inactive. `host_tq_pop` removes the queue head, and `host_dq_push` writes `host_dq_word` (bit DW is the header flag) into the data FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger number offered |
| trig_ready | output | 1 | Trigger queue has room |
| trig_num | input | 8 | Trigger number |
| bp_tnum | output | 8 | Trigger number on the backplane |
| bp_tvalid_n | output | 1 | Trigger-valid strobe, active low |
| bp_ready_n | input | NSLV | Per-slave data-ready lines, active low |
| bp_back | input | 1 | Wired board acknowledge, high when all slaves answered |
| bp_addr | output | AW | Selected slave address |
| bp_as_n | output | 1 | Address strobe, active low |
| bp_ds_n | output | 1 | Data strobe, active low |
| bp_dk_n | input | 1 | Data acknowledge, active low |
| bp_eob_n | input | 1 | End of block with the current word, active low |
| bp_data | input | DW | Slave data word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer can take a word |
| out_hdr | output | 1 | Output word is a frame header |
| out_data | output | DW | Output word |
| diag_mode | input | 1 | Keep off the bus; host access to FIFOs |
| host_tq_pop | input | 1 | Host removes trigger queue head (diagnostic) |
| tq_avail | output | 1 | Trigger queue not empty |
| tq_head | output | 8 | Trigger queue head |
| host_dq_push | input | 1 | Host writes a data FIFO word (diagnostic) |
| host_dq_word | input | DW+1 | Word for host write, bit DW is the header flag |
| tmo_limit | input | TOW | Response timeout in cycles, 0 disables |
| timeout_flag | output | 1 | A timeout ended the last transaction |
| frame_cycles | output | FCW | Duration of the latest transaction |

## Verification
A corrupted ready mask or address register shows on the output stream within one frame: words from a slave that did not claim data, a missing slave, or slaves out of order. A stuck sequencer state holds a strobe low or never releases one. The protocol monitors catch that on the same cycle, or `timeout_flag` rises within `tmo_limit` cycles. A frame timer that is off by one shows as a mismatch against the edge count between the trigger-valid fall and the last address-strobe rise, read as soon as the frame ends.

// File: rtl/erm_pkg.sv
package erm_pkg;
  localparam int unsigned TRIG_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TSET,
    ST_TACK,
    ST_TREL,
    ST_HDR,
    ST_ASET,
    ST_DREQ,
    ST_DACK,
    ST_DREL,
    ST_AREL
  } erm_state_e;
endpackage

// File: rtl/erm_fifo.sv
module erm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/erm_lowbit.sv
module erm_lowbit #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]                      vec,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx,
  output logic                              any
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/erm_watch.sv
module erm_watch #(
  parameter int unsigned TOW = 16,
  parameter int unsigned FCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           waiting,
  input  logic [TOW-1:0] tmo_lim,
  input  logic           frame_clr,
  input  logic           frame_end,
  output logic           expired,
  output logic [FCW-1:0] last_cycles
);
  logic [TOW-1:0] wait_cnt;
  logic [FCW-1:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               wait_cnt <= '0;
    else if (!waiting)        wait_cnt <= '0;
    else if (wait_cnt != '1)  wait_cnt <= wait_cnt + 1'b1;
  end

  assign expired = waiting && (tmo_lim != '0) && (wait_cnt == tmo_lim - TOW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt   <= '0;
      last_cycles <= '0;
    end else begin
      if (frame_clr)              frame_cnt <= '0;
      else if (frame_cnt != '1)   frame_cnt <= frame_cnt + 1'b1;
      if (frame_end)
        last_cycles <= (frame_cnt == '1) ? frame_cnt : frame_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evt_readout_master.sv
module evt_readout_master
  import erm_pkg::*;
#(
  parameter int unsigned NSLV     = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned TQ_DEPTH = 8,
  parameter int unsigned DQ_DEPTH = 16,
  parameter int unsigned SETUP    = 2,
  parameter int unsigned TOW      = 16,
  parameter int unsigned FCW      = 16,
  localparam int unsigned AW      = (NSLV > 1) ? $clog2(NSLV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [7:0]        trig_num,
  output logic [7:0]        bp_tnum,
  output logic              bp_tvalid_n,
  input  logic [NSLV-1:0]   bp_ready_n,
  input  logic              bp_back,
  output logic [AW-1:0]     bp_addr,
  output logic              bp_as_n,
  output logic              bp_ds_n,
  input  logic              bp_dk_n,
  input  logic              bp_eob_n,
  input  logic [DW-1:0]     bp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hdr,
  output logic [DW-1:0]     out_data,
  input  logic              diag_mode,
  input  logic              host_tq_pop,
  output logic              tq_avail,
  output logic [7:0]        tq_head,
  input  logic              host_dq_push,
  input  logic [DW:0]       host_dq_word,
  input  logic [TOW-1:0]    tmo_limit,
  output logic              timeout_flag,
  output logic [FCW-1:0]    frame_cycles
);
  localparam int unsigned FW  = DW + 1;
  localparam int unsigned SCW = $clog2(SETUP + 1);

  erm_state_e      state_q, state_d;
  logic [7:0]      tnum_q;
  logic [NSLV-1:0] mask_q, mask_clr;
  logic [AW-1:0]   addr_q, lo_idx;
  logic [SCW-1:0]  set_cnt;
  logic            eob_q, to_flag_q;
  logic            lo_any;

  logic            tq_push, tq_pop, tq_full, tq_empty;
  logic [7:0]      tq_dout;
  logic            dq_push, dq_pop, dq_full, dq_empty;
  logic [FW-1:0]   dq_din, dq_dout;
  logic            eng_push, host_push, host_pop;

  logic            waiting, abort, setup_done;
  logic            frame_clr, empty_end, last_end, frame_end;

  // trigger queue
  assign trig_ready = !tq_full;
  assign tq_push    = trig_valid && !tq_full;
  assign host_pop   = diag_mode && host_tq_pop && !tq_empty && (state_q == ST_IDLE);
  assign tq_pop     = ((state_q == ST_TACK) && (bp_back || abort)) || host_pop;
  assign tq_avail   = !tq_empty;
  assign tq_head    = tq_dout;

  erm_fifo #(.W(8), .DEPTH(TQ_DEPTH)) u_tq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tq_push),
    .din   (trig_num),
    .pop   (tq_pop),
    .dout  (tq_dout),
    .full  (tq_full),
    .empty (tq_empty)
  );

  // data FIFO, fed by the sequencer or, in diagnostic mode, by the host
  assign eng_push  = ((state_q == ST_HDR) && !dq_full) ||
                     ((state_q == ST_DACK) && !bp_dk_n);
  assign host_push = diag_mode && host_dq_push && !dq_full && (state_q == ST_IDLE);
  assign dq_push   = eng_push || host_push;

  always_comb begin
    if (state_q == ST_HDR)
      dq_din = {1'b1, {(DW - TRIG_W){1'b0}}, tnum_q};
    else if (state_q == ST_DACK)
      dq_din = {1'b0, bp_data};
    else
      dq_din = host_dq_word;
  end

  assign out_valid = !dq_empty;
  assign dq_pop    = out_valid && out_ready;
  assign out_hdr   = dq_dout[DW];
  assign out_data  = dq_dout[DW-1:0];

  erm_fifo #(.W(FW), .DEPTH(DQ_DEPTH)) u_dq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (dq_push),
    .din   (dq_din),
    .pop   (dq_pop),
    .dout  (dq_dout),
    .full  (dq_full),
    .empty (dq_empty)
  );

  // next claimed slave
  erm_lowbit #(.N(NSLV)) u_pick (
    .vec (mask_q),
    .idx (lo_idx),
    .any (lo_any)
  );

  assign mask_clr = mask_q & ~(NSLV'(1) << addr_q);

  // timeout and frame timing
  assign waiting = ((state_q == ST_TACK) && !bp_back)  ||
                   ((state_q == ST_TREL) &&  bp_back)  ||
                   ((state_q == ST_DACK) &&  bp_dk_n)  ||
                   ((state_q == ST_DREL) && !bp_dk_n);

  assign frame_clr = (state_q == ST_TSET);
  assign empty_end = (state_q == ST_TACK) && bp_back && (&bp_ready_n);
  assign last_end  = (state_q == ST_DREL) && bp_dk_n && eob_q && (mask_clr == '0);
  assign frame_end = empty_end || last_end || abort;

  erm_watch #(.TOW(TOW), .FCW(FCW)) u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .waiting     (waiting),
    .tmo_lim     (tmo_limit),
    .frame_clr   (frame_clr),
    .frame_end   (frame_end),
    .expired     (abort),
    .last_cycles (frame_cycles)
  );

  // sequencer
  assign setup_done = (set_cnt == SCW'(SETUP - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!diag_mode && !tq_empty) state_d = ST_TSET;
      ST_TSET: if (setup_done) state_d = ST_TACK;
      ST_TACK: begin
        if (abort)        state_d = ST_IDLE;
        else if (bp_back) state_d = ST_TREL;
      end
      ST_TREL: begin
        if (abort)         state_d = ST_IDLE;
        else if (!bp_back) state_d = (mask_q == '0) ? ST_IDLE : ST_HDR;
      end
      ST_HDR:  if (!dq_full) state_d = ST_ASET;
      ST_ASET: if (setup_done) state_d = ST_DREQ;
      ST_DREQ: if (!dq_full) state_d = ST_DACK;
      ST_DACK: begin
        if (abort)         state_d = ST_IDLE;
        else if (!bp_dk_n) state_d = ST_DREL;
      end
      ST_DREL: begin
        if (abort)        state_d = ST_IDLE;
        else if (bp_dk_n) state_d = eob_q ? ST_AREL : ST_DREQ;
      end
      ST_AREL: state_d = lo_any ? ST_ASET : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tnum_q    <= '0;
      mask_q    <= '0;
      addr_q    <= '0;
      set_cnt   <= '0;
      eob_q     <= 1'b0;
      to_flag_q <= 1'b0;
    end else begin
      state_q <= state_d;

      if (state_d != state_q)                               set_cnt <= '0;
      else if (state_q == ST_TSET || state_q == ST_ASET)    set_cnt <= set_cnt + 1'b1;

      if (state_q == ST_IDLE && state_d == ST_TSET) begin
        tnum_q    <= tq_dout;
        to_flag_q <= 1'b0;
      end

      if (state_q == ST_TACK && bp_back)                    mask_q <= ~bp_ready_n;
      if (state_q == ST_DACK && !bp_dk_n)                   eob_q  <= !bp_eob_n;
      if (state_q == ST_DREL && bp_dk_n && eob_q)           mask_q <= mask_clr;
      if ((state_q == ST_HDR || state_q == ST_AREL) && state_d == ST_ASET)
        addr_q <= lo_idx;

      if (abort) begin
        mask_q    <= '0;
        eob_q     <= 1'b0;
        to_flag_q <= 1'b1;
      end
    end
  end

  assign bp_tnum      = tnum_q;
  assign bp_tvalid_n  = (state_q != ST_TACK);
  assign bp_addr      = addr_q;
  assign bp_as_n      = !(state_q == ST_DREQ || state_q == ST_DACK || state_q == ST_DREL);
  assign bp_ds_n      = (state_q != ST_DACK);
  assign timeout_flag = to_flag_q;

  // protocol checks
  a_r2_tnum_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_tvalid_n && $past(!bp_tvalid_n)) |-> $stable(bp_tnum));
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bp_tvalid_n && !bp_as_n));
  a_r3_addr_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASET && $past(state_q) != ST_ASET) |-> mask_q[addr_q]);
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bp_as_n && $past(!bp_as_n)) |-> $stable(bp_addr));
  a_r5_ds_inside_as: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_ds_n |-> !bp_as_n);
  a_r5_ds_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bp_ds_n) |-> ($past(!bp_dk_n) || $past(abort)));
  a_r9_no_ds_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bp_ds_n) |-> $past(!dq_full));
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> (bp_tvalid_n && bp_as_n && bp_ds_n));
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_mode && $past(diag_mode) && $past(state_q) == ST_IDLE) |-> (bp_tvalid_n && bp_as_n));
endmodule

// File: tb/evt_readout_master_tb.sv
module evt_readout_master_tb;
  localparam int NSLV = 16;
  localparam int DW   = 16;
  localparam int SETUP = 2;
  localparam int TQD  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            trig_valid = 0, trig_ready;
  logic [7:0]      trig_num = 0;
  logic [7:0]      bp_tnum;
  logic            bp_tvalid_n;
  logic [NSLV-1:0] sl_rdy_n = '1;
  logic            sl_back = 0;
  logic [3:0]      bp_addr;
  logic            bp_as_n, bp_ds_n;
  logic            sl_dk_n = 1, sl_eob_n = 1;
  logic [DW-1:0]   sl_data = '0;
  logic            out_valid, out_ready = 0, out_hdr;
  logic [DW-1:0]   out_data;
  logic            diag_mode = 0, host_tq_pop = 0, tq_avail;
  logic [7:0]      tq_head;
  logic            host_dq_push = 0;
  logic [DW:0]     host_dq_word = '0;
  logic [15:0]     tmo_limit = 16'd200;
  logic            timeout_flag;
  logic [15:0]     frame_cycles;

  evt_readout_master u_dut (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_num(trig_num),
    .bp_tnum(bp_tnum), .bp_tvalid_n(bp_tvalid_n), .bp_ready_n(sl_rdy_n), .bp_back(sl_back),
    .bp_addr(bp_addr), .bp_as_n(bp_as_n), .bp_ds_n(bp_ds_n), .bp_dk_n(sl_dk_n),
    .bp_eob_n(sl_eob_n), .bp_data(sl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr), .out_data(out_data),
    .diag_mode(diag_mode), .host_tq_pop(host_tq_pop), .tq_avail(tq_avail), .tq_head(tq_head),
    .host_dq_push(host_dq_push), .host_dq_word(host_dq_word),
    .tmo_limit(tmo_limit), .timeout_flag(timeout_flag), .frame_cycles(frame_cycles)
  );

  int checks = 0, fails = 0;
  int cyc = 0, wd = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // slave population model
  logic [NSLV-1:0] has_data = '0;
  bit              ack_en = 1;
  int              sl_k = 0;

  function automatic int nw(input int a);
    return a % 3 + 1;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sl_back = 0; sl_rdy_n = '1; sl_dk_n = 1; sl_eob_n = 1; sl_k = 0;
    end else begin
      if (!bp_tvalid_n && ack_en) begin
        sl_back = 1; sl_rdy_n = ~has_data;
      end else if (bp_tvalid_n) begin
        sl_back = 0; sl_rdy_n = '1;
      end
      if (bp_as_n) begin
        sl_k = 0; sl_dk_n = 1; sl_eob_n = 1;
      end else if (!bp_ds_n && sl_dk_n && ack_en) begin
        sl_data  = {bp_addr, bp_tnum, 4'(sl_k)};
        sl_eob_n = (sl_k == nw(int'(bp_addr)) - 1) ? 1'b0 : 1'b1;
        sl_dk_n  = 0;
      end else if (bp_ds_n && !sl_dk_n) begin
        sl_dk_n = 1; sl_k++;
      end
    end
  end

  // output sink
  int              sink_mode = 1;
  logic [DW:0]     rx [64];
  int              rx_n = 0;

  always @(negedge clk) begin
    logic rdy;
    rdy = (sink_mode == 1) || (sink_mode == 2 && cyc % 3 == 0);
    if (out_valid && rdy && rst_n) begin
      if (rx_n < 64) rx[rx_n] = {out_hdr, out_data};
      rx_n++;
    end
    out_ready = rdy;
  end

  // bus monitor
  logic       prev_tv = 1, prev_as = 1;
  logic [7:0] prev_tnum = 0;
  logic [3:0] prev_addr = 0;
  int         tn_age = 0, ad_age = 0, setup_err = 0;
  int         n_tv_fall = 0, n_as_fall = 0, t_start = 0, t_end = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_tv && !bp_tvalid_n) begin
        n_tv_fall++; t_start = cyc;
        if (tn_age < SETUP) setup_err++;
      end
      if (prev_as && !bp_as_n) begin
        n_as_fall++;
        if (ad_age < SETUP) setup_err++;
      end
      if (!prev_as && bp_as_n) t_end = cyc;
      if (bp_tnum != prev_tnum) tn_age = bp_tvalid_n ? 1 : 0;
      else if (bp_tvalid_n) tn_age++;
      if (bp_addr != prev_addr) ad_age = bp_as_n ? 1 : 0;
      else if (bp_as_n) ad_age++;
    end
    prev_tv = bp_tvalid_n; prev_as = bp_as_n;
    prev_tnum = bp_tnum; prev_addr = bp_addr;
  end

  // expected stream
  logic [DW:0] exp_w [64];
  int          exp_n = 0;

  task automatic add_frame(input logic [7:0] t, input logic [NSLV-1:0] m);
    exp_w[exp_n++] = {1'b1, 8'h00, t};
    for (int a = 0; a < NSLV; a++)
      if (m[a])
        for (int k = 0; k < nw(a); k++)
          exp_w[exp_n++] = {1'b0, 4'(a), t, 4'(k)};
  endtask

  task automatic clear_books();
    @(negedge clk);
    rx_n = 0; exp_n = 0; n_tv_fall = 0; n_as_fall = 0; setup_err = 0;
  endtask

  task automatic push_trig(input logic [7:0] v);
    @(negedge clk);
    trig_valid = 1; trig_num = v;
    while (!trig_ready) @(negedge clk);
    @(negedge clk);
    trig_valid = 0;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 3000 && rx_n < n; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_stream(input string tag);
    chk(rx_n == exp_n, {tag, " word count"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk(rx[i] == exp_w[i], tag, rx[i], exp_w[i]);
  endtask

  // scenarios
  task automatic t_reset();
    chk(trig_ready == 1, "R1 reset trig_ready", trig_ready, 1);
    chk({bp_tvalid_n, bp_as_n, bp_ds_n} == 3'b111, "R2 reset strobes idle", {bp_tvalid_n, bp_as_n, bp_ds_n}, 3'b111);
    chk(out_valid == 0, "R9 reset out_valid", out_valid, 0);
    chk(timeout_flag == 0 && tq_avail == 0, "R10 reset flag/queue", {timeout_flag, tq_avail}, 0);
  endtask

  task automatic t_single();
    clear_books();
    has_data = 16'h0025; sink_mode = 1;
    add_frame(8'h3A, 16'h0025);
    push_trig(8'h3A);
    wait_rx(exp_n);
    check_stream("R3 R5 R6 R8 single frame");
    chk(n_as_fall == 3, "R3 slaves opened", n_as_fall, 3);
    chk(setup_err == 0, "R2 R4 setup time", setup_err, 0);
    chk(frame_cycles == 16'(t_end - t_start), "R11 frame timer", frame_cycles, t_end - t_start);
  endtask

  task automatic t_queue();
    clear_books();
    has_data = 16'h8001; sink_mode = 1;
    for (int i = 0; i < 3; i++) add_frame(8'(8'hA0 + i), 16'h8001);
    for (int i = 0; i < 3; i++) push_trig(8'(8'hA0 + i));
    wait_rx(exp_n);
    check_stream("R1 R3 queued frames in order");
    chk(n_tv_fall == 3, "R2 one broadcast per trigger", n_tv_fall, 3);
  endtask

  task automatic t_empty();
    clear_books();
    has_data = '0;
    push_trig(8'h55);
    repeat (40) @(negedge clk);
    chk(rx_n == 0, "R7 empty frame writes nothing", rx_n, 0);
    chk(n_as_fall == 0, "R7 empty frame opens no slave", n_as_fall, 0);
    chk(n_tv_fall == 1 && bp_tvalid_n, "R7 broadcast done", n_tv_fall, 1);
    has_data = 16'h0010;
    add_frame(8'h56, 16'h0010);
    push_trig(8'h56);
    wait_rx(exp_n);
    check_stream("R7 next trigger after empty");
  endtask

  task automatic t_backpressure();
    logic [DW:0] first;
    clear_books();
    has_data = '1; sink_mode = 0;
    add_frame(8'hC3, 16'hFFFF);
    push_trig(8'hC3);
    repeat (300) @(negedge clk);
    chk(out_valid == 1, "R9 output valid while full", out_valid, 1);
    chk({out_hdr, out_data} == {1'b1, 16'h00C3}, "R8 header first", {out_hdr, out_data}, {1'b1, 16'h00C3});
    chk(bp_ds_n == 1 && bp_as_n == 0, "R9 bus stalled on full FIFO", {bp_ds_n, bp_as_n}, 2'b10);
    first = {out_hdr, out_data};
    repeat (20) @(negedge clk);
    chk({out_hdr, out_data} == first, "R9 word held without ready", {out_hdr, out_data}, first);
    sink_mode = 2;
    wait_rx(exp_n);
    check_stream("R6 R9 stream under back-pressure");
    sink_mode = 1;
  endtask

  task automatic t_timeout();
    int low;
    clear_books();
    tmo_limit = 16'd10; ack_en = 0; has_data = '0;
    push_trig(8'h77);
    while (bp_tvalid_n) @(negedge clk);
    low = 0;
    while (!bp_tvalid_n && low < 500) begin low++; @(negedge clk); end
    chk(low == 10, "R10 wait ended after limit", low, 10);
    chk(timeout_flag == 1, "R10 timeout flag set", timeout_flag, 1);
    chk({bp_tvalid_n, bp_as_n, bp_ds_n} == 3'b111, "R10 strobes released", {bp_tvalid_n, bp_as_n, bp_ds_n}, 3'b111);
    chk(tq_avail == 0, "R10 trigger dropped", tq_avail, 0);
    chk(frame_cycles == 16'd10, "R11 timer on timeout", frame_cycles, 10);
    ack_en = 1; has_data = 16'h0002;
    add_frame(8'h78, 16'h0002);
    push_trig(8'h78);
    wait_rx(exp_n);
    check_stream("R10 recovery frame");
    chk(timeout_flag == 0, "R10 flag cleared by new cycle", timeout_flag, 0);
    tmo_limit = 16'd0; ack_en = 0; has_data = '0;
    push_trig(8'h79);
    repeat (100) @(negedge clk);
    chk(bp_tvalid_n == 0 && timeout_flag == 0, "R10 limit zero disables", {bp_tvalid_n, timeout_flag}, 0);
    ack_en = 1;
    repeat (10) @(negedge clk);
    chk(bp_tvalid_n == 1, "R10 late answer completes", bp_tvalid_n, 1);
    tmo_limit = 16'd200;
  endtask

  task automatic t_diag();
    clear_books();
    @(negedge clk); diag_mode = 1;
    for (int i = 0; i < TQD; i++) push_trig(8'(8'h10 + i));
    chk(trig_ready == 0, "R1 queue full drops ready", trig_ready, 0);
    repeat (20) @(negedge clk);
    chk(n_tv_fall == 0 && bp_tvalid_n && bp_as_n, "R12 bus untouched in diag", n_tv_fall, 0);
    for (int i = 0; i < TQD; i++) begin
      chk(tq_head == 8'(8'h10 + i), "R1 R12 queue order via host", tq_head, 8'h10 + i);
      host_tq_pop = 1;
      @(negedge clk);
      host_tq_pop = 0;
    end
    chk(tq_avail == 0, "R12 host emptied queue", tq_avail, 0);
    host_dq_push = 1; host_dq_word = {1'b0, 16'hBEEF};
    @(negedge clk);
    host_dq_push = 0;
    repeat (4) @(negedge clk);
    chk(rx_n == 1 && rx[0] == {1'b0, 16'hBEEF}, "R12 host word on output", rx[0], {1'b0, 16'hBEEF});
    diag_mode = 0;
    repeat (10) @(negedge clk);
    chk(n_tv_fall == 0, "R12 no frame after diag", n_tv_fall, 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_queue();
    t_empty();
    t_backpressure();
    t_timeout();
    t_diag();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule